// File: doc/BRIEF.md
# MII Carrier, Collision and Loopback Controller

This block is the control logic on the MII side of one 10/100 PHY port. It derives carrier sense and collision from the MAC's transmit enable and the line's receive activity, taking the speed and duplex of the link into account. It also chooses what the MAC sees on its receive data. Normally that is line data. It is the MAC's own transmit data when either the diagnostic loopback is set or the echo path of a 10 Mbps half-duplex link is active. The block can also force halt code groups onto the 100 Mbps transmit path.

The MII has no back-pressure. `tx_en` qualifies `txd` and `rx_dv` qualifies `rxd`, and each side must accept a beat on every clock in which its valid is high, so there are no ready signals. Carrier sense and collision come from combinational logic. The receive data and its valid pass through one register stage whatever their source. Code-group encoding, auto-negotiation and register access belong elsewhere, and this block only consumes the two control bits.

Top module: `mii_lpbk_ctl`

## Requirements
- R1: While `rst_n` is low, `rxd` is 0 and `rx_dv` is 0.
- R2: `crs` is high exactly when line receive activity counts (`line_rx_act` high and `lb_test` low), or when `tx_en` is high on a half-duplex link (`full_dup` low). In full duplex, transmission alone never raises `crs`.
- R3: `col` is high exactly when `full_dup` is low, `tx_en` is high and line receive activity counts.
- R4: Echo loopback is active when `spd_100`=0, `full_dup`=0, `echo_dis`=0 and `tx_en`=1. It makes `rxd`/`rx_dv` equal to `txd`/`tx_en` one clock later.
- R5: With `lb_test` low, echo loopback stays off if any of these holds: `spd_100`=1, `full_dup`=1 or `echo_dis`=1. `rxd`/`rx_dv` then equal `line_rxd`/`line_rx_dv` one clock later.
- R6: With `lb_test`=1, `rxd`/`rx_dv` equal `txd`/`tx_en` one clock later, at either speed and in either duplex mode.
- R7: `line_en` is 0 exactly when `lb_test` is 1.
- R8: With `lb_test`=1, `line_rx_act`, `line_rxd` and `line_rx_dv` have no effect. `col` stays 0, and `crs` follows only the transmit rule of R2.
- R9: `tx_cg_sel` is 1 exactly when `spd_100`, `tx_en` and `tx_er` are all 1. `tx_cg` then carries the halt code group 5'b00100, and it is 5'b00000 otherwise. At 10 Mbps, `tx_er` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side MII clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | MAC transmit enable (valid for `txd`) |
| txd | input | 4 | MAC transmit nibble |
| tx_er | input | 1 | MAC transmit error |
| line_rx_act | input | 1 | Receive activity detected on the line |
| line_rxd | input | 4 | Receive nibble from the line side |
| line_rx_dv | input | 1 | Valid for `line_rxd` |
| spd_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dup | input | 1 | 1 = full duplex |
| lb_test | input | 1 | Diagnostic loopback control bit |
| echo_dis | input | 1 | Disables the 10 Mbps half-duplex echo |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| rxd | output | 4 | Receive nibble to the MAC |
| rx_dv | output | 1 | Valid for `rxd` |
| line_en | output | 1 | Enables the twisted-pair/fiber interface |
| tx_cg_sel | output | 1 | 1 = transmit path sends `tx_cg` instead of encoded data |
| tx_cg | output | 5 | Forced transmit code group |

## Verification
The assertions assume a few things about the inputs. Every input changes only between rising clock edges. Speed, duplex and the two control bits are management settings and may change between any two beats. `line_rx_dv` is high only while `line_rx_act` is high. The stimulus changes inputs only on the falling edge, and it derives `line_rx_dv` as a subset of `line_rx_act`. Directed phases switch the mode bits mid-stream so that the boundary cycle, where the receive source changes, is covered as well as the random beats.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int CG_W = 5;
  localparam logic [CG_W-1:0] HALT_CG = 5'b00100;
  localparam logic [CG_W-1:0] IDLE_FORCE = '0;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_LOOP = 1'b1
  } rx_src_e;
endpackage

// File: rtl/mlc_sense.sv
module mlc_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic line_rx_act,
  input  logic full_dup,
  input  logic lb_test,
  output logic crs,
  output logic col
);
  logic rx_seen;
  logic tx_counts;

  // Line activity is masked while the line is cut off for diagnostics.
  always_comb begin
    rx_seen   = line_rx_act & ~lb_test;
    tx_counts = tx_en & ~full_dup;
    crs       = rx_seen | tx_counts;
    col       = tx_counts & rx_seen;
  end

  AST_COL_HALF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> (!full_dup && tx_en && line_rx_act)); // R3
  AST_CRS_NO_TX_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup && !line_rx_act) |-> !crs); // R2
  AST_NO_COL_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    lb_test |-> !col); // R8
endmodule

// File: rtl/mlc_rxpath.sv
module mlc_rxpath
  import mlc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_src_e           src,
  input  logic [DATA_W-1:0] txd,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] line_rxd,
  input  logic              line_rx_dv,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_dv
);
  logic [DATA_W-1:0] d_nxt;
  logic              v_nxt;

  always_comb begin
    if (src == SRC_LOOP) begin
      d_nxt = txd;
      v_nxt = tx_en;
    end else begin
      d_nxt = line_rxd;
      v_nxt = line_rx_dv;
    end
  end

  // Single stage for both sources keeps the MAC-side latency uniform.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd   <= '0;
      rx_dv <= 1'b0;
    end else begin
      rxd   <= d_nxt;
      rx_dv <= v_nxt;
    end
  end

  AST_LOOP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_LOOP) |=> (rxd == $past(txd) && rx_dv == $past(tx_en))); // R4
endmodule

// File: rtl/mlc_txsel.sv
module mlc_txsel
  import mlc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spd_100,
  input  logic            tx_en,
  input  logic            tx_er,
  output logic            cg_sel,
  output logic [CG_W-1:0] cg
);
  always_comb begin
    cg_sel = spd_100 & tx_en & tx_er;
    cg     = cg_sel ? HALT_CG : IDLE_FORCE;
  end

  AST_HALT_100_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> (spd_100 && tx_er)); // R9
  AST_HALT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> (cg == 5'b00100)); // R9
endmodule

// File: rtl/mii_lpbk_ctl.sv
module mii_lpbk_ctl
  import mlc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] txd,
  input  logic              tx_er,
  input  logic              line_rx_act,
  input  logic [DATA_W-1:0] line_rxd,
  input  logic              line_rx_dv,
  input  logic              spd_100,
  input  logic              full_dup,
  input  logic              lb_test,
  input  logic              echo_dis,
  output logic              crs,
  output logic              col,
  output logic [DATA_W-1:0] rxd,
  output logic              rx_dv,
  output logic              line_en,
  output logic              tx_cg_sel,
  output logic [CG_W-1:0]   tx_cg
);
  logic    echo_ok;
  rx_src_e rx_src;

  always_comb begin
    echo_ok = ~spd_100 & ~full_dup & ~echo_dis;
    line_en = ~lb_test;
    rx_src  = (lb_test || (echo_ok && tx_en)) ? SRC_LOOP : SRC_LINE;
  end

  mlc_sense u_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .line_rx_act (line_rx_act),
    .full_dup    (full_dup),
    .lb_test     (lb_test),
    .crs         (crs),
    .col         (col)
  );

  mlc_rxpath #(.DATA_W(DATA_W)) u_rxpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (rx_src),
    .txd        (txd),
    .tx_en      (tx_en),
    .line_rxd   (line_rxd),
    .line_rx_dv (line_rx_dv),
    .rxd        (rxd),
    .rx_dv      (rx_dv)
  );

  mlc_txsel u_txsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .spd_100 (spd_100),
    .tx_en   (tx_en),
    .tx_er   (tx_er),
    .cg_sel  (tx_cg_sel),
    .cg      (tx_cg)
  );

  AST_LINE_OFF_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    lb_test |-> !line_en); // R7
  AST_ECHO_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_test && (spd_100 || full_dup || echo_dis))
      |=> (rxd == $past(line_rxd) && rx_dv == $past(line_rx_dv))); // R5
endmodule

// File: tb/tb_mii_lpbk_ctl.sv
module tb_mii_lpbk_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 0, tx_er = 0, line_rx_act = 0, line_rx_dv = 0;
  logic [3:0] txd = '0, line_rxd = '0;
  logic spd_100 = 0, full_dup = 0, lb_test = 0, echo_dis = 0;
  logic crs, col, rx_dv, line_en, tx_cg_sel;
  logic [3:0] rxd;
  logic [4:0] tx_cg;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [4:0] exp_q[$];  // {dv, data} expected one clock later

  always #10 clk = ~clk;  // 50 MHz

  mii_lpbk_ctl dut (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one beat at the falling edge, check the comb outputs and the
  // registered outputs from the previous beat, then queue this beat's result.
  task automatic beat(bit te, bit [3:0] d, bit er, bit ract, bit [3:0] rd, bit rdv,
                      bit s100, bit fd, bit lbt, bit edis);
    bit rx_ok, loop;
    logic [4:0] e;
    @(negedge clk);
    tx_en = te; txd = d; tx_er = er; line_rx_act = ract; line_rxd = rd;
    line_rx_dv = rdv & ract; spd_100 = s100; full_dup = fd; lb_test = lbt; echo_dis = edis;
    #5;
    rx_ok = ract && !lbt;
    chk(lbt ? "R8" : "R2", "crs", crs, rx_ok || (te && !fd));
    chk(lbt ? "R8" : "R3", "col", col, rx_ok && te && !fd);
    chk("R7", "line_en", line_en, !lbt);
    chk("R9", "tx_cg_sel", tx_cg_sel, s100 && te && er);
    chk("R9", "tx_cg", tx_cg, (s100 && te && er) ? 5'b00100 : 5'b00000);
    e = exp_q.pop_front();
    chk(lbt ? "R6" : "R4_R5", "rxd", rxd, e[3:0]);
    chk(lbt ? "R6" : "R4_R5", "rx_dv", rx_dv, e[4]);
    loop = lbt || (!s100 && !fd && !edis && te);
    exp_q.push_back(loop ? {te, d} : {rdv & ract, rd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    line_rx_act = 1; line_rxd = 4'hA; line_rx_dv = 1; tx_en = 1; txd = 4'h5;
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "rxd in reset", rxd, 0);
    chk("R1", "rx_dv in reset", rx_dv, 0);
    @(negedge clk);
    line_rx_act = 0; line_rxd = 0; line_rx_dv = 0; tx_en = 0; txd = 0;
    @(negedge clk);
    rst_n = 1;
    exp_q.push_back(5'h00);
    // R4: 10 Mbps half-duplex echo
    for (int i = 0; i < 6; i++) beat(1, 4'(i + 3), 0, 0, 4'h0, 0, 0, 0, 0, 0);
    // R3: echo plus line activity -> collision, echo wins on rxd
    beat(1, 4'h9, 0, 1, 4'h6, 1, 0, 0, 0, 0);
    beat(0, 4'h0, 0, 1, 4'h6, 1, 0, 0, 0, 0);
    // R5: suppressed by disable bit, 100M, full duplex
    beat(1, 4'h1, 0, 1, 4'hC, 1, 0, 0, 0, 1);
    beat(1, 4'h2, 0, 1, 4'hD, 1, 1, 0, 0, 0);
    beat(1, 4'h3, 0, 1, 4'hE, 1, 0, 1, 0, 0);
    beat(1, 4'h4, 0, 0, 4'h0, 0, 0, 1, 0, 0);  // R2: full-duplex tx alone, no crs
    // R9: halt at 100M, none at 10M
    beat(1, 4'h7, 1, 0, 4'h0, 0, 1, 1, 0, 0);
    beat(1, 4'h7, 1, 0, 4'h0, 0, 0, 1, 0, 0);
    beat(0, 4'h7, 1, 0, 4'h0, 0, 1, 0, 0, 0);
    // R6/R8: test loopback at both speeds/duplexes with line noise
    for (int i = 0; i < 8; i++)
      beat(i[0], 4'(15 - i), 0, 1, 4'h8, 1, i[1], i[2], 1, i[0]);
    beat(0, 4'h0, 0, 1, 4'hB, 1, 1, 1, 0, 0);
    // random beats
    for (int i = 0; i < 600; i++)
      beat($urandom_range(0, 1), 4'($urandom), $urandom_range(0, 1), $urandom_range(0, 1),
           4'($urandom), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule